// File: doc/BRIEF.md
# Dual-Channel DAC Sample Input Port

This block sits between a pair of external parallel sample buses and the datapath of a dual DAC. It watches a data clock that arrives as an ordinary input, finds the active edge of that clock in the core clock domain, and captures sample words on it. Which edge counts as active, rising or falling, is set by a configuration input. Each captured word is converted to two's complement if the source sends offset binary.

There are two capture modes. In dual-bus mode every active edge captures the I word from bus A and the Q word from bus B together. In shared-bus mode only bus A carries samples. The top bit of bus B is reused as a channel select, because its pin doubles as that select line. A Q word must arrive first and an I word completes the pair. Out-of-order words set a sticky sequence error. Each complete pair appears on the outputs with a one-cycle valid pulse.

Top module: `dac_in_port`

## Requirements
- R1: While rst_ni is low and after its release, i_o and q_o read zero and valid_o and seq_err_o read 0 until the first capture.
- R2: In dual-bus mode (dual_mode_i=1) each active data-clock edge captures bus_a_i as I and bus_b_i as Q. valid_o is high for exactly one clock, on the third rising clk edge counting from the first rising clk edge that samples the new dclk_i level.
- R3: fall_edge_i=0 makes rising dclk_i transitions active and fall_edge_i=1 makes falling transitions active. A transition in the other direction captures nothing and raises no valid_o.
- R4: With offset_bin_i=1 a captured word has its most significant bit (bit W-1) inverted, so 0x0000 becomes 0x2000 for W=14. With offset_bin_i=0 the word passes unchanged.
- R5: In shared-bus mode (dual_mode_i=0) only bus_a_i carries data. bus_b_i[W-1]=1 marks an I word and 0 marks a Q word, and the other bus_b_i bits are ignored. An I word that follows a held Q word emits the pair {I, held Q} with the R2 latency.
- R6: In shared-bus mode a Q word that arrives while a Q word is already held replaces the held word and sets seq_err_o. The pair completed later carries the newest Q.
- R7: In shared-bus mode an I word with no held Q emits no pair and sets seq_err_o. This includes the first word after reset and an I word that directly follows a completed pair.
- R8: seq_err_o stays set until reset. Pair emission continues normally while it is set. Dual-bus mode never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dual_mode_i | input | 1 | 1: two buses, 0: shared bus with select |
| fall_edge_i | input | 1 | 1: capture on falling data-clock edge |
| offset_bin_i | input | 1 | 1: input words are offset binary |
| dclk_i | input | 1 | Data clock, sampled by clk_i |
| bus_a_i | input | W | Sample bus A |
| bus_b_i | input | W | Sample bus B; top bit is the channel select in shared-bus mode |
| i_o | output | W | I sample, two's complement |
| q_o | output | W | Q sample, two's complement |
| valid_o | output | 1 | One-cycle pulse per complete pair |
| seq_err_o | output | 1 | Sticky shared-bus ordering error |

## Verification
Two things can land on the same capture edge: a pair completing and the sticky error being set or already set. A repeated Q followed by an I produces both the error and a pair whose Q must be the newest word. Pairs that complete while the error is already set must still come out on time. The bench also lines up format conversion with channel steering: in shared-bus mode the select bit is taken raw while the data bits are converted. Random select sequences with a fixed seed, checked against a bench model of the pairing state, cover every order of these events under all eight combinations of mode, edge and format.

// File: rtl/dac_in_pkg.sv
package dac_in_pkg;
  typedef enum logic {CH_Q = 1'b0, CH_I = 1'b1} chan_e;

  function automatic logic [13:0] unused_stub(input logic [13:0] x);
    return x;
  endfunction
endpackage

// File: rtl/dac_in_edge.sv
module dac_in_edge #(
  parameter int W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fall_edge_i,
  input  logic         dclk_i,
  input  logic [W-1:0] bus_a_i,
  input  logic [W-1:0] bus_b_i,
  output logic         cap_o,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o
);
  logic dclk_s1, dclk_s2;
  logic [W-1:0] a_s1, b_s1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dclk_s1 <= 1'b0;
      dclk_s2 <= 1'b0;
      a_s1    <= '0;
      b_s1    <= '0;
    end else begin
      dclk_s1 <= dclk_i;
      dclk_s2 <= dclk_s1;
      a_s1    <= bus_a_i;
      b_s1    <= bus_b_i;
    end
  end

  always_comb begin
    if (fall_edge_i) cap_o = dclk_s2 & ~dclk_s1;
    else             cap_o = dclk_s1 & ~dclk_s2;
  end

  assign a_o = a_s1;
  assign b_o = b_s1;

  // R3: the same data-clock level cannot yield two captures back to back
  p_edge_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |=> !cap_o);
endmodule

// File: rtl/dac_in_fmt.sv
module dac_in_fmt #(
  parameter int W     = 14,
  parameter int LANES = 2
) (
  input  logic                     offset_bin_i,
  input  logic [LANES-1:0][W-1:0]  raw_i,
  output logic [LANES-1:0][W-1:0]  tc_o
);
  localparam int MSB = W - 1;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      tc_o[g]      = raw_i[g];
      tc_o[g][MSB] = raw_i[g][MSB] ^ offset_bin_i;
    end
  end
endmodule

// File: rtl/dac_in_pair.sv
module dac_in_pair
  import dac_in_pkg::*;
#(
  parameter int W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         dual_mode_i,
  input  logic         cap_i,
  input  chan_e        sel_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         pair_vld_o,
  output logic [W-1:0] pair_i_o,
  output logic [W-1:0] pair_q_o,
  output logic         err_o
);
  logic [W-1:0] held_i, held_q;
  logic         have_q, err_q, vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_i <= '0;
      held_q <= '0;
      have_q <= 1'b0;
      err_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (cap_i) begin
        if (dual_mode_i) begin
          held_i <= a_i;
          held_q <= b_i;
          have_q <= 1'b0;
          vld_q  <= 1'b1;
        end else if (sel_i == CH_I) begin
          held_i <= a_i;
          if (have_q) begin
            vld_q  <= 1'b1;
            have_q <= 1'b0;
          end else begin
            err_q <= 1'b1;
          end
        end else begin
          held_q <= a_i;
          if (have_q) err_q <= 1'b1;
          have_q <= 1'b1;
        end
      end
    end
  end

  assign pair_vld_o = vld_q;
  assign pair_i_o   = held_i;
  assign pair_q_o   = held_q;
  assign err_o      = err_q;

  // R8: error flag is sticky
  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  // R5: a pair only follows a capture
  p_pair_after_cap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> $past(cap_i));
  // R5: in shared-bus mode only an I word completes a pair
  p_single_emit_on_i_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && !$past(dual_mode_i)) |-> ($past(sel_i) == CH_I));
endmodule

// File: rtl/dac_in_port.sv
module dac_in_port
  import dac_in_pkg::*;
#(
  parameter int W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         dual_mode_i,
  input  logic         fall_edge_i,
  input  logic         offset_bin_i,
  input  logic         dclk_i,
  input  logic [W-1:0] bus_a_i,
  input  logic [W-1:0] bus_b_i,
  output logic [W-1:0] i_o,
  output logic [W-1:0] q_o,
  output logic         valid_o,
  output logic         seq_err_o
);
  localparam int LANES = 2;

  logic                    cap;
  logic [W-1:0]            a_s, b_s;
  logic [LANES-1:0][W-1:0] raw, tc;
  logic                    pair_vld;
  logic [W-1:0]            pair_i, pair_q;
  chan_e                   sel;

  dac_in_edge #(.W(W)) u_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fall_edge_i (fall_edge_i),
    .dclk_i      (dclk_i),
    .bus_a_i     (bus_a_i),
    .bus_b_i     (bus_b_i),
    .cap_o       (cap),
    .a_o         (a_s),
    .b_o         (b_s)
  );

  assign raw[0] = a_s;
  assign raw[1] = b_s;
  // select bit is taken raw, before format conversion
  assign sel    = chan_e'(b_s[W-1]);

  dac_in_fmt #(.W(W), .LANES(LANES)) u_fmt (
    .offset_bin_i (offset_bin_i),
    .raw_i        (raw),
    .tc_o         (tc)
  );

  dac_in_pair #(.W(W)) u_pair (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dual_mode_i (dual_mode_i),
    .cap_i       (cap),
    .sel_i       (sel),
    .a_i         (tc[0]),
    .b_i         (tc[1]),
    .pair_vld_o  (pair_vld),
    .pair_i_o    (pair_i),
    .pair_q_o    (pair_q),
    .err_o       (seq_err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i_o     <= '0;
      q_o     <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= pair_vld;
      if (pair_vld) begin
        i_o <= pair_i;
        q_o <= pair_q;
      end
    end
  end

  // R2: valid is a single-cycle pulse
  p_valid_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R2: outputs hold between pairs
  p_hold_outputs_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(pair_vld) |-> ($stable(i_o) && $stable(q_o)));
endmodule

// File: tb/tb_dac_in_port.sv
module tb_dac_in_port;
  localparam int W = 14;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         dual_mode_i = 1'b1;
  logic         fall_edge_i = 1'b0;
  logic         offset_bin_i = 1'b0;
  logic         dclk_i = 1'b0;
  logic [W-1:0] bus_a_i = '0;
  logic [W-1:0] bus_b_i = '0;
  logic [W-1:0] i_o, q_o;
  logic         valid_o, seq_err_o;

  int n_chk = 0;
  int n_err = 0;
  int cycles = 0;

  // model state
  logic [W-1:0] m_q;
  logic         m_have_q, m_err;
  logic [W-1:0] m_last_i, m_last_q;

  always #4 clk_i = ~clk_i;

  dac_in_port #(.W(W)) dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dual_mode_i  (dual_mode_i),
    .fall_edge_i  (fall_edge_i),
    .offset_bin_i (offset_bin_i),
    .dclk_i       (dclk_i),
    .bus_a_i      (bus_a_i),
    .bus_b_i      (bus_b_i),
    .i_o          (i_o),
    .q_o          (q_o),
    .valid_o      (valid_o),
    .seq_err_o    (seq_err_o)
  );

  function automatic logic [W-1:0] conv(input logic [W-1:0] w, input logic ob);
    conv = ob ? {~w[W-1], w[W-2:0]} : w;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  task automatic do_reset(input logic dual, input logic fall, input logic ob);
    @(negedge clk_i);
    rst_ni       = 1'b0;
    dual_mode_i  = dual;
    fall_edge_i  = fall;
    offset_bin_i = ob;
    dclk_i       = fall;
    bus_a_i      = '0;
    bus_b_i      = '0;
    repeat (3) @(negedge clk_i);
    check(i_o == 0 && q_o == 0 && !valid_o && !seq_err_o, "R1 reset",
          {i_o, q_o, valid_o, seq_err_o}, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check(!valid_o && !seq_err_o && i_o == 0, "R1 after release",
          {valid_o, seq_err_o}, 0);
    m_have_q = 1'b0;
    m_err    = 1'b0;
    m_q      = '0;
    m_last_i = '0;
    m_last_q = '0;
  endtask

  // one word transfer: inactive level with data, then active level
  task automatic word(input logic [W-1:0] a, input logic [W-1:0] b);
    logic exp_v;
    logic [W-1:0] ea, eb;
    ea = conv(a, offset_bin_i);
    eb = conv(b, offset_bin_i);
    exp_v = 1'b0;
    bus_a_i = a;
    bus_b_i = b;
    dclk_i  = fall_edge_i;
    repeat (3) @(negedge clk_i);
    check(valid_o == 1'b0, "R3 inactive edge ignored", valid_o, 0);
    dclk_i = ~fall_edge_i;
    if (dual_mode_i) begin
      exp_v = 1'b1;
      m_last_i = ea;
      m_last_q = eb;
    end else if (b[W-1]) begin
      if (m_have_q) begin
        exp_v = 1'b1;
        m_last_i = ea;
        m_last_q = m_q;
        m_have_q = 1'b0;
      end else begin
        m_err = 1'b1; // R7
      end
    end else begin
      if (m_have_q) m_err = 1'b1; // R6
      m_q = ea;
      m_have_q = 1'b1;
    end
    repeat (2) @(negedge clk_i);
    check(valid_o == 1'b0, "R2 latency early", valid_o, 0);
    @(negedge clk_i);
    check(valid_o == exp_v, "R2/R5 valid pulse", valid_o, exp_v);
    if (exp_v) begin
      check(i_o == m_last_i, dual_mode_i ? "R2 I word" : "R5 I word", i_o, m_last_i);
      check(q_o == m_last_q, dual_mode_i ? "R2 Q word" : "R6 Q word", q_o, m_last_q);
    end
    check(seq_err_o == m_err, "R8 error flag", seq_err_o, m_err);
    @(negedge clk_i);
    check(valid_o == 1'b0, "R2 single pulse", valid_o, 0);
  endtask

  function automatic logic [W-1:0] sw(input logic is_i, input logic [W-1:0] junk);
    sw = {is_i, junk[W-2:0]};
  endfunction

  initial begin
    void'($urandom(32'h5eed_1234));

    // directed: dual, rising, two's complement
    do_reset(1'b1, 1'b0, 1'b0);
    word(14'h1234, 14'h2abc);
    word(14'h3fff, 14'h0000);
    // directed R4: offset binary zero maps to 0x2000
    do_reset(1'b1, 1'b1, 1'b1);
    word(14'h0000, 14'h3fff);
    check(i_o == 14'h2000 && q_o == 14'h1fff, "R4 offset conversion", {i_o, q_o},
          {14'h2000, 14'h1fff});
    // directed shared bus: I first (R7), Q Q I (R6), I after pair (R7)
    do_reset(1'b0, 1'b0, 1'b0);
    word(14'h0111, sw(1'b1, 14'h0aaa));
    check(seq_err_o == 1'b1, "R7 first I sets error", seq_err_o, 1);
    do_reset(1'b0, 1'b1, 1'b1);
    word(14'h0222, sw(1'b0, 14'h1555));
    word(14'h0333, sw(1'b0, 14'h0000));
    word(14'h0444, sw(1'b1, 14'h3fff));
    check(q_o == conv(14'h0333, 1'b1), "R6 newest Q", q_o, conv(14'h0333, 1'b1));
    word(14'h0555, sw(1'b1, 14'h0000));
    word(14'h0666, sw(1'b0, 14'h0000));
    word(14'h0777, sw(1'b1, 14'h0000));
    check(seq_err_o == 1'b1, "R8 sticky with pairs", seq_err_o, 1);

    // random across all configurations
    for (int cfg = 0; cfg < 8; cfg++) begin
      do_reset(cfg[0], cfg[1], cfg[2]);
      for (int k = 0; k < 30; k++) begin
        logic [W-1:0] ra, rb;
        ra = W'($urandom);
        rb = W'($urandom);
        if (!dual_mode_i) begin
          // bias toward correct Q/I alternation
          if (($urandom % 5) != 0) rb[W-1] = m_have_q;
        end
        word(ra, rb);
      end
      if (cfg[0]) check(seq_err_o == 1'b0, "R8 dual never errs", seq_err_o, 0);
    end

    finish_run();
  end
endmodule